// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two radix-2 signed-digit vectors of `W` digits, where each digit is -1, 0 or +1. Because the representation is redundant, the sum is built in three local steps per column. First, the two input digits are split into an interim digit and a transfer to the next column. Second, that interim digit and the incoming transfer are split again. Third, the pieces are merged into the final digit. A transfer never travels further than one column, so the logic depth is the same for every width.

Each digit travels on two wires: `2'b00` is 0, `2'b01` is +1 and `2'b11` is -1. The result has `W+2` digits. Column `W` is an internal pad column with zero inputs, and digit `W+1` holds the second-step transfer that leaves that pad column. This lets the sum of any two inputs be stated without a lookahead across columns. The block is purely combinational and is meant to sit between registers in a wider arithmetic datapath, for example a partial-product reduction tree.

Top module: `sd_carry_free_adder`

## Requirements
- R1: Input digit codes are 00 = 0, 01 = +1, 11 = -1; an input code 10 is read as 0.
- R2: Every output digit carries one of the codes 00, 01 or 11 and never 10.
- R3: The signed value of `sum_o` (digit i weighted by 2^i) equals the value of `x_i` plus the value of `y_i`, for every input pair.
- R4: The first step maps a column sum to (transfer, interim): +2 to (+1, 0), +1 to (+1, -1), 0 to (0, 0), -1 to (0, -1), -2 to (-1, 0). So when every input digit is +1, the sum has digit 0 = 0, digits 1..W = +1 and digit W+1 = 0.
- R5: The second step maps interim plus incoming transfer to (transfer, kept digit): +1 to (0, +1), 0 to (0, 0), -1 to (-1, +1), -2 to (-1, 0). So when every input digit is -1, the sum has digit 1 = +1, digit W+1 = -1 and all other digits 0.
- R6: Digit 0 of the sum receives no transfer: it is +1 when the two input digits 0 add to an odd value, and 0 otherwise.
- R7: Digit W+1 of the sum is never +1, and it is -1 only when the sum is negative.
- R8: Output digit i depends only on input columns i, i-1 and i-2, so changing input digit k leaves every output digit outside k..k+2 unchanged.
- R9: All-zero inputs give an all-zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 2*W | First addend, digit i on bits 2i+1:2i |
| y_i | input | 2*W | Second addend, same layout |
| sum_o | output | 2*(W+2) | Signed-digit sum, digit i on bits 2i+1:2i |

## Verification
The checks inside the column modules run on every evaluation and cover the following:
- each first-step split keeps the column value and an interim digit that is never +1;
- each second-step split keeps the value, with the kept digit never -1 and the outgoing transfer never +1;
- every merged column lands in the digit range.

Properties that span the whole vector can only be shown by the bench's scenarios. These are:
- numeric equality of the sum;
- the exact digit patterns produced by all-ones inputs;
- the sign rule on the top digit;
- the locality of a single-digit change.

The bench covers them with an exhaustive sweep of a three-digit instance, including invalid codes, and random vectors on a 24-digit instance.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

   typedef logic [1:0]        sd_code_t;
   typedef logic signed [2:0] sd_val_t;

   localparam sd_code_t SD_ZERO = 2'b00;
   localparam sd_code_t SD_POS  = 2'b01;
   localparam sd_code_t SD_NEG  = 2'b11;

   // Code to value; the unused code 2'b10 reads as zero (R1)
   function automatic sd_val_t sd_decode(input sd_code_t c);
      case (c)
         SD_POS:  return 3'sd1;
         SD_NEG:  return -3'sd1;
         default: return 3'sd0;
      endcase
   endfunction

   // Value in -1..1 to code
   function automatic sd_code_t sd_encode(input sd_val_t v);
      case (v)
         3'sd1:   return SD_POS;
         -3'sd1:  return SD_NEG;
         default: return SD_ZERO;
      endcase
   endfunction

endpackage

// File: rtl/sdadd_transfer1.sv
// First step: column sum of two input digits -> transfer up + interim digit
module sdadd_transfer1
   import sdadd_pkg::*;
(
   input  sd_code_t a_i,
   input  sd_code_t b_i,
   output sd_code_t carry_o,
   output sd_code_t rest_o
);

   always_comb begin
      sd_val_t col;
      sd_val_t back;
      col = sd_decode(a_i) + sd_decode(b_i);
      case (col)
         3'sd2:   begin carry_o = SD_POS;  rest_o = SD_ZERO; end
         3'sd1:   begin carry_o = SD_POS;  rest_o = SD_NEG;  end
         -3'sd1:  begin carry_o = SD_ZERO; rest_o = SD_NEG;  end
         -3'sd2:  begin carry_o = SD_NEG;  rest_o = SD_ZERO; end
         default: begin carry_o = SD_ZERO; rest_o = SD_ZERO; end
      endcase
      back = sd_decode(rest_o) + (sd_decode(carry_o) <<< 1);
      if (!$isunknown({a_i, b_i})) begin
         assert_interim_set_R4: assert (rest_o == SD_ZERO || rest_o == SD_NEG)
            else $error("first-step interim digit left {-1,0}");
         assert_split1_value_R3: assert (back == col)
            else $error("first-step split changed the column value");
      end
   end

endmodule

// File: rtl/sdadd_transfer2.sv
// Second step: interim digit + incoming transfer -> transfer up + kept digit
module sdadd_transfer2
   import sdadd_pkg::*;
(
   input  sd_code_t rest_i,
   input  sd_code_t carry_i,
   output sd_code_t carry_o,
   output sd_code_t keep_o
);

   always_comb begin
      sd_val_t col;
      sd_val_t back;
      col = sd_decode(rest_i) + sd_decode(carry_i);
      case (col)
         3'sd1:   begin carry_o = SD_ZERO; keep_o = SD_POS;  end
         -3'sd1:  begin carry_o = SD_NEG;  keep_o = SD_POS;  end
         -3'sd2:  begin carry_o = SD_NEG;  keep_o = SD_ZERO; end
         default: begin carry_o = SD_ZERO; keep_o = SD_ZERO; end
      endcase
      back = sd_decode(keep_o) + (sd_decode(carry_o) <<< 1);
      if (!$isunknown({rest_i, carry_i})) begin
         assert_keep_set_R5: assert (keep_o == SD_ZERO || keep_o == SD_POS)
            else $error("second-step kept digit left {0,1}");
         assert_carry_set_R5: assert (carry_o == SD_ZERO || carry_o == SD_NEG)
            else $error("second-step transfer left {-1,0}");
         assert_split2_value_R3: assert (back == col)
            else $error("second-step split changed the column value");
      end
   end

endmodule

// File: rtl/sdadd_merge.sv
// Third step: kept digit + incoming second-step transfer -> final digit
module sdadd_merge
   import sdadd_pkg::*;
(
   input  sd_code_t keep_i,
   input  sd_code_t carry_i,
   output sd_code_t sum_o
);

   always_comb begin
      sd_val_t col;
      col   = sd_decode(keep_i) + sd_decode(carry_i);
      sum_o = sd_encode(col);
      if (!$isunknown({keep_i, carry_i})) begin
         assert_digit_range_R2: assert (col >= -3'sd1 && col <= 3'sd1)
            else $error("merged column outside the digit range");
      end
   end

endmodule

// File: rtl/sd_carry_free_adder.sv
module sd_carry_free_adder
   import sdadd_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [2*W-1:0]     x_i,
   input  logic [2*W-1:0]     y_i,
   output logic [2*(W+2)-1:0] sum_o
);

   localparam int NCOL = W + 1;   // live columns plus one pad column
   localparam int NOUT = W + 2;   // result digits

   if (W < 1) begin : g_bad_width
      $error("sd_carry_free_adder: W must be at least 1");
   end

   // t1[i]: first-step transfer into column i (t1[0] is the empty entry)
   logic [NCOL-1:0][1:0] t1;
   logic [NCOL-1:0][1:0] v;
   // t2[i-1]: second-step transfer into column i, i = 1..NCOL
   logic [NCOL-1:0][1:0] t2;
   logic [NCOL-1:0][1:0] w;

   assign t1[0] = SD_ZERO;

   for (genvar i = 0; i < NCOL; i++) begin : g_col
      if (i < W) begin : g_live
         sdadd_transfer1 u_t1 (
            .a_i    (x_i[2*i +: 2]),
            .b_i    (y_i[2*i +: 2]),
            .carry_o(t1[i+1]),
            .rest_o (v[i])
         );
      end else begin : g_pad
         assign v[i] = SD_ZERO;
      end

      sdadd_transfer2 u_t2 (
         .rest_i (v[i]),
         .carry_i(t1[i]),
         .carry_o(t2[i]),
         .keep_o (w[i])
      );

      if (i == 0) begin : g_lsd
         assign sum_o[1:0] = w[0];
      end else begin : g_upper
         sdadd_merge u_m (
            .keep_i (w[i]),
            .carry_i(t2[i-1]),
            .sum_o  (sum_o[2*i +: 2])
         );
      end
   end

   assign sum_o[2*NOUT-1 -: 2] = t2[NCOL-1];

endmodule

// File: tb/sim_sd_carry_free_adder.sv
module sim_sd_carry_free_adder;

   localparam int WS = 3;
   localparam int WB = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   logic [2*WS-1:0]     xs, ys;
   logic [2*(WS+2)-1:0] ss;
   logic [2*WB-1:0]     xb, yb;
   logic [2*(WB+2)-1:0] sb;

   always #(2.5ns) clk = ~clk;

   sd_carry_free_adder #(.W(WS)) u0 (.x_i(xs), .y_i(ys), .sum_o(ss));
   sd_carry_free_adder #(.W(WB)) u1 (.x_i(xb), .y_i(yb), .sum_o(sb));

   function automatic int dig(input logic [63:0] v, input int i);
      case (v[2*i +: 2])
         2'b01:   return 1;
         2'b11:   return -1;
         2'b10:   return 2;   // flags the unused code
         default: return 0;
      endcase
   endfunction

   function automatic longint sd_value(input logic [63:0] v, input int n);
      longint acc = 0;
      for (int i = 0; i < n; i++) begin
         if (dig(v, i) == 1)  acc += (longint'(1) << i);
         if (dig(v, i) == -1) acc -= (longint'(1) << i);
      end
      return acc;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_sum(input logic [63:0] x, input logic [63:0] y,
                            input logic [63:0] s, input int n);
      longint exp_v, act_v;
      int bad, d0, e0, top;
      exp_v = sd_value(x, n) + sd_value(y, n);
      act_v = sd_value(s, n + 2);
      check(act_v == exp_v, "R3 value", act_v, exp_v);
      bad = 0;
      for (int i = 0; i < n + 2; i++) if (dig(s, i) == 2) bad++;
      check(bad == 0, "R2 code10 count", bad, 0);
      d0 = dig(s, 0);
      e0 = ((((dig(x, 0) == 2) ? 0 : dig(x, 0)) + ((dig(y, 0) == 2) ? 0 : dig(y, 0))) % 2 != 0) ? 1 : 0;
      check(d0 == e0, "R6 digit0", d0, e0);
      top = dig(s, n + 1);
      check(top == 0 || (top == -1 && exp_v < 0), "R7 top digit", top, 0);
   endtask

   initial begin
      logic [2*(WB+2)-1:0] expv;
      logic [2*(WB+2)-1:0] base;
      xs = '0; ys = '0; xb = '0; yb = '0;
      repeat (4) @(posedge clk);
      rst = 1'b0;

      // Reset state / zero inputs (R9)
      @(negedge clk);
      check(ss == '0, "R9 small zero", longint'(ss), 0);
      check(sb == '0, "R9 wide zero", longint'(sb), 0);

      // Unused code reads as zero (R1)
      @(posedge clk);
      xs = {WS{2'b10}}; ys = {WS{2'b10}}; xb = {WB{2'b10}}; yb = {WB{2'b10}};
      @(negedge clk);
      check(ss == '0, "R1 small all code10", longint'(ss), 0);
      check(sb == '0, "R1 wide all code10", longint'(sb), 0);
      @(posedge clk);
      xb = {WB{2'b10}}; yb = '0; yb[1:0] = 2'b01;
      @(negedge clk);
      check(sd_value(sb, WB + 2) == 1, "R1 code10 plus one", sd_value(sb, WB + 2), 1);

      // All +1 inputs: first-step pattern (R4)
      @(posedge clk);
      xb = {WB{2'b01}}; yb = {WB{2'b01}};
      expv = '0;
      for (int i = 1; i <= WB; i++) expv[2*i +: 2] = 2'b01;
      @(negedge clk);
      check(sb == expv, "R4 all-plus pattern", longint'(sb), longint'(expv));
      check_sum(64'(xb), 64'(yb), 64'(sb), WB);

      // All -1 inputs: second-step pattern (R5)
      @(posedge clk);
      xb = {WB{2'b11}}; yb = {WB{2'b11}};
      expv = '0;
      expv[3:2] = 2'b01;
      expv[2*(WB+1) +: 2] = 2'b11;
      @(negedge clk);
      check(sb == expv, "R5 all-minus pattern", longint'(sb), longint'(expv));
      check_sum(64'(xb), 64'(yb), 64'(sb), WB);

      // Exhaustive small width with random wide vectors alongside (R2 R3 R6 R7)
      for (int n = 0; n < 4096; n++) begin
         @(posedge clk);
         xs = n[5:0];
         ys = n[11:6];
         for (int i = 0; i < WB; i++) begin
            xb[2*i +: 2] = 2'($urandom);
            yb[2*i +: 2] = 2'($urandom);
         end
         @(negedge clk);
         check_sum(64'(xs), 64'(ys), 64'(ss), WS);
         check_sum(64'(xb), 64'(yb), 64'(sb), WB);
      end

      // Locality of a single-digit change (R8)
      for (int r = 0; r < 300; r++) begin
         int k;
         int diffs;
         @(posedge clk);
         for (int i = 0; i < WB; i++) begin
            xb[2*i +: 2] = 2'($urandom);
            yb[2*i +: 2] = 2'($urandom);
         end
         @(negedge clk);
         base = sb;
         k = int'($urandom % WB);
         @(posedge clk);
         case (xb[2*k +: 2])
            2'b01:   xb[2*k +: 2] = 2'b11;
            2'b11:   xb[2*k +: 2] = 2'b00;
            default: xb[2*k +: 2] = 2'b01;
         endcase
         @(negedge clk);
         diffs = 0;
         for (int j = 0; j < WB + 2; j++)
            if ((j < k || j > k + 2) && sb[2*j +: 2] != base[2*j +: 2]) diffs++;
         check(diffs == 0, "R8 digits changed outside window", diffs, 0);
         check_sum(64'(xb), 64'(yb), 64'(sb), WB);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule